// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Steering

This block sits between the pin core of a 32-line GPIO unit and the interrupt inputs of a four-CPU cluster. Every cycle it receives two vectors from the pin core: one with a one-cycle pulse for each pin where an edge was seen, and one with the pin levels after polarity adjustment. It keeps a separate edge-cause, edge-mask and level-mask set for each CPU. It also keeps one shared global set. A CPU only sees, masks and acknowledges the state in its own set, so one CPU taking an interrupt does not hide it from the others.

Each set turns its state into request lines, one per group of eight pins. A group's line is high when a pin in that group is pending. A pin is pending when its level mask bit is set and its data-in is high, or when its edge mask bit and its latched edge cause bit are both set. Software reaches the registers over a simple single-cycle register port. That port has a window-select bit that picks between the main window, which holds the global set, and the per-CPU window, which holds the replicated sets at a fixed four-byte stride.

Top module: `gpio_irq_steer`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears every cause and mask register in every set. All request lines are low from the cycle after reset, whatever data_in is.
- R2: With bus_win=1 (per-CPU window), CPU n reaches three registers: its edge cause at offset n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4, for n=0..3. Mask registers read back the value last written to them.
- R3: With bus_win=0 (main window), the global edge cause sits at 0x14, the global edge mask at 0x18 and the global level mask at 0x1C.
- R4: A 1 on edge_evt[i] at a clock edge sets bit i in all four per-CPU cause registers and in the global cause register.
- R5: A write to a cause register clears each bit written as 0 and keeps each bit written as 1. No other set's cause register changes.
- R6: When an edge event and a clearing cause write hit the same bit in the same cycle, the bit ends up set.
- R7: Request line cpu_irq[c*4+g] is the OR over pins 8g..8g+7 of (level mask AND data_in) OR (edge cause AND edge mask) of CPU c, with no register delay.
- R8: global_irq[g] follows the same rule as R7, using the global set.
- R9: Reads of any offset not listed in R2 or R3 return 0, and writes to such offsets change no register. bus_rdata is 0 whenever bus_en is low.
- R10: A write to one CPU's mask register leaves the masks of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = main window, 1 = per-CPU window |
| bus_addr | input | 8 | Byte offset in the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| edge_evt | input | 32 | One-cycle edge pulse per pin from the pin core |
| data_in | input | 32 | Polarity-adjusted pin levels from the pin core |
| cpu_irq | output | 16 | Requests, index CPU*4 + group |
| global_irq | output | 4 | Requests of the global set, one per group |

## Verification
The bench builds the block with its defaults: 32 pins in groups of eight, four CPUs, and the global set present. This means the first and last group, the first and last CPU, and the main-window registers can all be reached with short stimulus. The vector table places mask patterns and edge events so that each CPU lights a different group. One wrong stride, group index or shared register therefore moves a request to a visibly wrong bit. Directed cases then cover the event-versus-clear collision, the unmapped offsets and a second reset taken while data_in is high.

// File: rtl/gpio_steer_pkg.sv
package gpio_steer_pkg;

   // Kind of register selected by the window decoder
   typedef enum logic [1:0] {
      REG_NONE  = 2'd0,
      REG_CAUSE = 2'd1,
      REG_EMASK = 2'd2,
      REG_LMASK = 2'd3
   } reg_kind_e;

   // Per-CPU window layout: three banks, one word per CPU in each
   localparam int unsigned PC_STRIDE     = 4;
   localparam int unsigned PC_CAUSE_BASE = 'h00;
   localparam int unsigned PC_EMASK_BASE = 'h10;
   localparam int unsigned PC_LMASK_BASE = 'h20;
   localparam int unsigned PC_BANK_SPAN  = PC_EMASK_BASE - PC_CAUSE_BASE;

   // Main window: shared set
   localparam int unsigned GL_CAUSE_OFS  = 'h14;
   localparam int unsigned GL_EMASK_OFS  = 'h18;
   localparam int unsigned GL_LMASK_OFS  = 'h1C;

endpackage

// File: rtl/gpio_grp_or.sv
module gpio_grp_or #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned GROUP_W = 8,
   localparam int unsigned NGRP   = WIDTH / GROUP_W
) (
   input  logic [WIDTH-1:0] vec,
   output logic [NGRP-1:0]  any
);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign any[g] = |vec[g*GROUP_W +: GROUP_W];
   end

endmodule

// File: rtl/gpio_irq_view.sv
module gpio_irq_view #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned GROUP_W  = 8,
   localparam int unsigned NGRP    = NUM_PINS / GROUP_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] edge_evt,
   input  logic [NUM_PINS-1:0] data_in,
   input  logic                cause_wr,
   input  logic                emask_wr,
   input  logic                lmask_wr,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] cause,
   output logic [NUM_PINS-1:0] emask,
   output logic [NUM_PINS-1:0] lmask,
   output logic [NGRP-1:0]     irq
);

   logic [NUM_PINS-1:0] cause_kept;
   logic [NUM_PINS-1:0] pending;

   // Zeros in an acknowledge write clear; a new edge always wins
   assign cause_kept = cause_wr ? (cause & wdata) : cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         emask <= '0;
         lmask <= '0;
      end else begin
         cause <= cause_kept | edge_evt;
         if (emask_wr) emask <= wdata;
         if (lmask_wr) lmask <= wdata;
      end
   end

   assign pending = (lmask & data_in) | (cause & emask);

   gpio_grp_or #(
      .WIDTH   (NUM_PINS),
      .GROUP_W (GROUP_W)
   ) u_grp (
      .vec (pending),
      .any (irq)
   );

endmodule

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
   import gpio_steer_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_CPUS    = 4,
   parameter bit          GLOBAL_VIEW = 1'b1,
   localparam int unsigned NVIEW      = NUM_CPUS + 1
) (
   input  logic              bus_win,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NVIEW-1:0]  sel_view,
   output reg_kind_e         sel_kind,
   output logic              hit
);

   // Slot NUM_CPUS is the global set
   always_comb begin
      sel_view = '0;
      sel_kind = REG_NONE;
      if (!bus_win) begin
         if (GLOBAL_VIEW) begin
            if (bus_addr == ADDR_W'(GL_CAUSE_OFS)) begin
               sel_view[NUM_CPUS] = 1'b1;
               sel_kind           = REG_CAUSE;
            end else if (bus_addr == ADDR_W'(GL_EMASK_OFS)) begin
               sel_view[NUM_CPUS] = 1'b1;
               sel_kind           = REG_EMASK;
            end else if (bus_addr == ADDR_W'(GL_LMASK_OFS)) begin
               sel_view[NUM_CPUS] = 1'b1;
               sel_kind           = REG_LMASK;
            end
         end
      end else begin
         for (int c = 0; c < NUM_CPUS; c++) begin
            if (bus_addr == ADDR_W'(PC_CAUSE_BASE + c*PC_STRIDE)) begin
               sel_view[c] = 1'b1;
               sel_kind    = REG_CAUSE;
            end
            if (bus_addr == ADDR_W'(PC_EMASK_BASE + c*PC_STRIDE)) begin
               sel_view[c] = 1'b1;
               sel_kind    = REG_EMASK;
            end
            if (bus_addr == ADDR_W'(PC_LMASK_BASE + c*PC_STRIDE)) begin
               sel_view[c] = 1'b1;
               sel_kind    = REG_LMASK;
            end
         end
      end
   end

   assign hit = (sel_kind != REG_NONE);

endmodule

// File: rtl/gpio_irq_steer.sv
module gpio_irq_steer
   import gpio_steer_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned NUM_CPUS    = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter bit          GLOBAL_VIEW = 1'b1,
   localparam int unsigned NGRP       = NUM_PINS / GROUP_W,
   localparam int unsigned NVIEW      = NUM_CPUS + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_en,
   input  logic                     bus_we,
   input  logic                     bus_win,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [NUM_PINS-1:0]      bus_wdata,
   output logic [NUM_PINS-1:0]      bus_rdata,
   input  logic [NUM_PINS-1:0]      edge_evt,
   input  logic [NUM_PINS-1:0]      data_in,
   output logic [NUM_CPUS*NGRP-1:0] cpu_irq,
   output logic [NGRP-1:0]          global_irq
);

   // Elaboration-time parameter checks
   if (NUM_PINS % GROUP_W != 0) begin : g_bad_group
      $error("NUM_PINS must be a multiple of GROUP_W");
   end
   if (NUM_PINS > 32) begin : g_bad_pins
      $error("NUM_PINS is limited to one 32-bit word");
   end
   if (NUM_CPUS * PC_STRIDE > PC_BANK_SPAN) begin : g_bad_cpus
      $error("per-CPU banks would overlap");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the per-CPU window");
   end

   logic [NVIEW-1:0] sel_view;
   reg_kind_e        sel_kind;
   logic             rd_hit;
   logic             wr_go;

   logic [NUM_PINS-1:0] v_cause [NVIEW];
   logic [NUM_PINS-1:0] v_emask [NVIEW];
   logic [NUM_PINS-1:0] v_lmask [NVIEW];
   logic [NGRP-1:0]     v_irq   [NVIEW];
   logic [NVIEW-1:0]    v_cause_wr;
   logic [NVIEW-1:0]    v_emask_wr;
   logic [NVIEW-1:0]    v_lmask_wr;

   // Flattened per-CPU state for the bound checker
   logic [NUM_CPUS*NUM_PINS-1:0] pc_cause_flat;
   logic [NUM_CPUS*NUM_PINS-1:0] pc_emask_flat;
   logic [NUM_CPUS*NUM_PINS-1:0] pc_lmask_flat;
   logic [NUM_CPUS-1:0]          pc_cause_wr;

   gpio_win_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_CPUS    (NUM_CPUS),
      .GLOBAL_VIEW (GLOBAL_VIEW)
   ) u_dec (
      .bus_win  (bus_win),
      .bus_addr (bus_addr),
      .sel_view (sel_view),
      .sel_kind (sel_kind),
      .hit      (rd_hit)
   );

   assign wr_go = bus_en & bus_we;

   for (genvar v = 0; v < NVIEW; v++) begin : g_strobe
      assign v_cause_wr[v] = wr_go & sel_view[v] & (sel_kind == REG_CAUSE);
      assign v_emask_wr[v] = wr_go & sel_view[v] & (sel_kind == REG_EMASK);
      assign v_lmask_wr[v] = wr_go & sel_view[v] & (sel_kind == REG_LMASK);
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      gpio_irq_view #(
         .NUM_PINS (NUM_PINS),
         .GROUP_W  (GROUP_W)
      ) u_view (
         .clk      (clk),
         .rst_n    (rst_n),
         .edge_evt (edge_evt),
         .data_in  (data_in),
         .cause_wr (v_cause_wr[c]),
         .emask_wr (v_emask_wr[c]),
         .lmask_wr (v_lmask_wr[c]),
         .wdata    (bus_wdata),
         .cause    (v_cause[c]),
         .emask    (v_emask[c]),
         .lmask    (v_lmask[c]),
         .irq      (v_irq[c])
      );
      assign cpu_irq[c*NGRP +: NGRP]           = v_irq[c];
      assign pc_cause_flat[c*NUM_PINS +: NUM_PINS] = v_cause[c];
      assign pc_emask_flat[c*NUM_PINS +: NUM_PINS] = v_emask[c];
      assign pc_lmask_flat[c*NUM_PINS +: NUM_PINS] = v_lmask[c];
      assign pc_cause_wr[c]                    = v_cause_wr[c];
   end

   if (GLOBAL_VIEW) begin : g_glob
      gpio_irq_view #(
         .NUM_PINS (NUM_PINS),
         .GROUP_W  (GROUP_W)
      ) u_view (
         .clk      (clk),
         .rst_n    (rst_n),
         .edge_evt (edge_evt),
         .data_in  (data_in),
         .cause_wr (v_cause_wr[NUM_CPUS]),
         .emask_wr (v_emask_wr[NUM_CPUS]),
         .lmask_wr (v_lmask_wr[NUM_CPUS]),
         .wdata    (bus_wdata),
         .cause    (v_cause[NUM_CPUS]),
         .emask    (v_emask[NUM_CPUS]),
         .lmask    (v_lmask[NUM_CPUS]),
         .irq      (v_irq[NUM_CPUS])
      );
   end else begin : g_no_glob
      assign v_cause[NUM_CPUS] = '0;
      assign v_emask[NUM_CPUS] = '0;
      assign v_lmask[NUM_CPUS] = '0;
      assign v_irq[NUM_CPUS]   = '0;
   end

   assign global_irq = v_irq[NUM_CPUS];

   // Read mux: one-hot view select, kind picks the register
   always_comb begin
      bus_rdata = '0;
      if (bus_en) begin
         for (int v = 0; v < NVIEW; v++) begin
            if (sel_view[v]) begin
               unique case (sel_kind)
                  REG_CAUSE: bus_rdata = bus_rdata | v_cause[v];
                  REG_EMASK: bus_rdata = bus_rdata | v_emask[v];
                  REG_LMASK: bus_rdata = bus_rdata | v_lmask[v];
                  default:   bus_rdata = bus_rdata;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/gpio_irq_steer_chk.sv
module gpio_irq_steer_chk #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned GROUP_W  = 8,
   parameter int unsigned NUM_CPUS = 4,
   localparam int unsigned NGRP    = NUM_PINS / GROUP_W
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_en,
   input logic [NUM_PINS-1:0]          bus_rdata,
   input logic                         rd_hit,
   input logic [NUM_PINS-1:0]          edge_evt,
   input logic [NUM_CPUS*NUM_PINS-1:0] cause_flat,
   input logic [NUM_CPUS*NUM_PINS-1:0] emask_flat,
   input logic [NUM_CPUS*NUM_PINS-1:0] lmask_flat,
   input logic [NUM_CPUS-1:0]          cause_wr,
   input logic [NUM_CPUS*NGRP-1:0]     cpu_irq
);

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      // R4: every event bit lands in this CPU's cause
      p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((cause_flat[c*NUM_PINS +: NUM_PINS] & $past(edge_evt)) == $past(edge_evt)));

      // R5: without a write to this cause, bits only accumulate
      p_cause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !cause_wr[c] |=> (cause_flat[c*NUM_PINS +: NUM_PINS] ==
                           ($past(cause_flat[c*NUM_PINS +: NUM_PINS]) | $past(edge_evt))));

      // R7: fully masked CPU raises no request
      p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (emask_flat[c*NUM_PINS +: NUM_PINS] == '0 && lmask_flat[c*NUM_PINS +: NUM_PINS] == '0)
         |-> (cpu_irq[c*NGRP +: NGRP] == '0));
   end

   // R9: unmapped or idle accesses return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_en || !rd_hit) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_steer gpio_irq_steer_chk #(
   .NUM_PINS (NUM_PINS),
   .GROUP_W  (GROUP_W),
   .NUM_CPUS (NUM_CPUS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en     (bus_en),
   .bus_rdata  (bus_rdata),
   .rd_hit     (rd_hit),
   .edge_evt   (edge_evt),
   .cause_flat (pc_cause_flat),
   .emask_flat (pc_emask_flat),
   .lmask_flat (pc_lmask_flat),
   .cause_wr   (pc_cause_wr),
   .cpu_irq    (cpu_irq)
);

// File: tb/gpio_irq_steer_test.sv
module gpio_irq_steer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_win = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] edge_evt = '0;
   logic [31:0] data_in = '0;
   logic [15:0] cpu_irq;
   logic [3:0]  global_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   gpio_irq_steer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_win    (bus_win),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .edge_evt   (edge_evt),
      .data_in    (data_in),
      .cpu_irq    (cpu_irq),
      .global_irq (global_irq)
   );

   typedef enum logic [2:0] {V_WR, V_RD, V_EVT, V_DIN, V_IRQ, V_GIRQ} vop_e;
   typedef struct packed {
      vop_e        op;
      logic        win;
      logic [7:0]  addr;
      logic [31:0] val;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t TBL [NV] = '{
      '{V_WR,   1'b1, 8'h10, 32'h0000_00FF, 32'h0, 4'd2},   // R2 cpu0 edge mask
      '{V_WR,   1'b1, 8'h14, 32'hFF00_0000, 32'h0, 4'd2},   // R2 cpu1 edge mask
      '{V_RD,   1'b1, 8'h10, 32'h0, 32'h0000_00FF, 4'd2},   // R2
      '{V_RD,   1'b1, 8'h14, 32'h0, 32'hFF00_0000, 4'd2},   // R2
      '{V_RD,   1'b1, 8'h18, 32'h0, 32'h0000_0000, 4'd10},  // R10 cpu2 untouched
      '{V_RD,   1'b1, 8'h1C, 32'h0, 32'h0000_0000, 4'd10},  // R10 cpu3 untouched
      '{V_EVT,  1'b0, 8'h00, 32'h8000_0001, 32'h0, 4'd4},   // R4 edges on pins 0, 31
      '{V_RD,   1'b1, 8'h00, 32'h0, 32'h8000_0001, 4'd4},   // R4 cpu0 cause
      '{V_RD,   1'b1, 8'h0C, 32'h0, 32'h8000_0001, 4'd4},   // R4 cpu3 cause
      '{V_RD,   1'b0, 8'h14, 32'h0, 32'h8000_0001, 4'd4},   // R4 global cause
      '{V_IRQ,  1'b0, 8'h00, 32'h0, 32'h0000_0081, 4'd7},   // R7 cpu0 g0, cpu1 g3
      '{V_WR,   1'b1, 8'h00, 32'hFFFF_FFFE, 32'h0, 4'd5},   // R5 ack pin0 on cpu0
      '{V_RD,   1'b1, 8'h00, 32'h0, 32'h8000_0000, 4'd5},   // R5
      '{V_RD,   1'b1, 8'h04, 32'h0, 32'h8000_0001, 4'd5},   // R5 cpu1 kept
      '{V_IRQ,  1'b0, 8'h00, 32'h0, 32'h0000_0080, 4'd7},   // R7
      '{V_WR,   1'b1, 8'h28, 32'h0000_FF00, 32'h0, 4'd2},   // R2 cpu2 level mask
      '{V_DIN,  1'b0, 8'h00, 32'h0000_0100, 32'h0, 4'd7},
      '{V_IRQ,  1'b0, 8'h00, 32'h0, 32'h0000_0280, 4'd7},   // R7 cpu2 g1 level
      '{V_RD,   1'b1, 8'h28, 32'h0, 32'h0000_FF00, 4'd2},   // R2
      '{V_WR,   1'b0, 8'h1C, 32'h00FF_0000, 32'h0, 4'd3},   // R3 global level mask
      '{V_RD,   1'b0, 8'h1C, 32'h0, 32'h00FF_0000, 4'd3},   // R3
      '{V_GIRQ, 1'b0, 8'h00, 32'h0, 32'h0000_0000, 4'd8},   // R8
      '{V_DIN,  1'b0, 8'h00, 32'h0001_0100, 32'h0, 4'd8},
      '{V_GIRQ, 1'b0, 8'h00, 32'h0, 32'h0000_0004, 4'd8},   // R8 global g2
      '{V_IRQ,  1'b0, 8'h00, 32'h0, 32'h0000_0280, 4'd7},   // R7 unchanged
      '{V_WR,   1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 4'd9},   // R9 unmapped write
      '{V_RD,   1'b1, 8'h30, 32'h0, 32'h0000_0000, 4'd9},   // R9
      '{V_RD,   1'b1, 8'h00, 32'h0, 32'h8000_0000, 4'd9},   // R9 cause unchanged
      '{V_RD,   1'b0, 8'h00, 32'h0, 32'h0000_0000, 4'd9},   // R9 main unmapped
      '{V_WR,   1'b0, 8'h18, 32'h8000_0000, 32'h0, 4'd3},   // R3 global edge mask
      '{V_GIRQ, 1'b0, 8'h00, 32'h0, 32'h0000_000C, 4'd8},   // R8 g2 + g3
      '{V_WR,   1'b0, 8'h14, 32'h0000_0000, 32'h0, 4'd5}    // R5 global ack all
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic win, logic [7:0] addr, logic [31:0] data);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_win = win; bus_addr = addr; bus_wdata = data;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(logic win, logic [7:0] addr, output logic [31:0] data);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_win = win; bus_addr = addr;
      #2 data = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic pulse_edges(logic [31:0] pins);
      @(negedge clk);
      edge_evt = pins;
      @(negedge clk);
      edge_evt = '0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of all registers and requests
      for (int c = 0; c < 4; c++) begin
         bus_read(1'b1, 8'(c*4), rd);        check("R1 cpu cause", rd, 32'h0);
         bus_read(1'b1, 8'(8'h10 + c*4), rd); check("R1 cpu emask", rd, 32'h0);
         bus_read(1'b1, 8'(8'h20 + c*4), rd); check("R1 cpu lmask", rd, 32'h0);
      end
      bus_read(1'b0, 8'h14, rd); check("R1 global cause", rd, 32'h0);
      bus_read(1'b0, 8'h18, rd); check("R1 global emask", rd, 32'h0);
      bus_read(1'b0, 8'h1C, rd); check("R1 global lmask", rd, 32'h0);
      #2 check("R1 cpu_irq", {16'h0, cpu_irq}, 32'h0);
      check("R1 global_irq", {28'h0, global_irq}, 32'h0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
         case (TBL[i].op)
            V_WR:  bus_write(TBL[i].win, TBL[i].addr, TBL[i].val);
            V_RD:  begin bus_read(TBL[i].win, TBL[i].addr, rd); check(tag, rd, TBL[i].exp); end
            V_EVT: pulse_edges(TBL[i].val);
            V_DIN: begin @(negedge clk); data_in = TBL[i].val; end
            V_IRQ: begin @(negedge clk); #2 check(tag, {16'h0, cpu_irq}, TBL[i].exp); end
            V_GIRQ: begin @(negedge clk); #2 check(tag, {28'h0, global_irq}, TBL[i].exp); end
            default: ;
         endcase
      end

      // R5: global ack leaves per-CPU causes alone; R8 after ack
      @(negedge clk); #2 check("R8 global after ack", {28'h0, global_irq}, 32'h4);
      bus_read(1'b1, 8'h04, rd); check("R5 cpu1 after global ack", rd, 32'h8000_0001);

      // R6: event and clearing write to the same bit in one cycle
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_win = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0;
      edge_evt = 32'h0000_0020;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; edge_evt = '0;
      bus_read(1'b1, 8'h0C, rd); check("R6 cpu3 cause", rd, 32'h0000_0020);
      bus_read(1'b1, 8'h00, rd); check("R4 cpu0 cause", rd, 32'h8000_0020);
      #2 check("R7 cpu0 g0 from new edge", {16'h0, cpu_irq}, 32'h0000_0281);

      // R9: idle bus reads zero
      @(negedge clk); bus_addr = 8'h10; bus_win = 1'b1;
      #2 check("R9 idle rdata", bus_rdata, 32'h0);

      // R1: second reset while data_in still high
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #2 check("R1 cpu_irq after reset", {16'h0, cpu_irq}, 32'h0);
      check("R1 global_irq after reset", {28'h0, global_irq}, 32'h0);
      bus_read(1'b1, 8'h28, rd); check("R1 cpu2 lmask after reset", rd, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule